// File: doc/BRIEF.md
# Battery Discharge Switch Short-Circuit Hiccup Controller

This block drives the enable of the switch that feeds the system from the battery when no input supply is present. The switch closes as soon as the battery is reported above its undervoltage level. The start of the system rail regulator waits until the battery has stayed above that level for a qualification time. All timing is counted in periods of an external timebase tick, so the same logic serves any tick rate.

While the switch is closed, the block watches a current-limit flag from the analog sense circuit. If that flag stays high for a trip window, the switch opens, a fault flag sets, and a recovery period starts. When the recovery period ends, the switch closes again to test whether the short has gone. This open/retry cycle repeats for as long as the limit keeps tripping. The fault flag clears after a retry during which the limit stays low for a full window.

Battery undervoltage overrides everything. It opens the switch, blocks any retry and drops the rail enable.

Top module: `dsg_hiccup_ctrl`

## Requirements
- R1: After reset, `sw_en`, `rail_en` and `fault` are all 0.
- R2: With `sw_en` low and no fault recovery in progress, `sw_en` goes to 1 one clock after `batt_ok` is seen high, with no qualification delay.
- R3: `rail_en` goes to 1 once `batt_ok` has been high for QUAL_TICKS ticks in a row, visible in the clock after the last counted tick. It goes to 0 one clock after `batt_ok` is seen low. It stays 1 through hiccup cycles while `batt_ok` stays high.
- R4: While the switch is on, `ilim` high on TRIP_TICKS consecutive ticks turns `sw_en` off and sets `fault` one clock after the last counted tick.
- R5: Any clock with `ilim` low before the trip count is reached restarts the trip count from zero.
- R6: After a trip, `sw_en` stays 0 for OFF_TICKS ticks and returns to 1 one clock after the last of them.
- R7: If `ilim` is still high after a retry, the trip and off period repeat without limit, and `fault` stays 1 throughout.
- R8: `fault` clears one clock after the switch has been on for TRIP_TICKS consecutive ticks with `ilim` low. It does not clear earlier.
- R9: `batt_ok` low turns `sw_en` off one clock later from any state. No retry happens while `batt_ok` is low. `fault` keeps its value across the undervoltage period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-clock timebase pulse; all periods are counted in these |
| batt_ok | input | 1 | Battery above undervoltage level |
| ilim | input | 1 | Discharge current limit active |
| sw_en | output | 1 | Battery discharge switch enable |
| rail_en | output | 1 | System rail regulator start enable |
| fault | output | 1 | Short-circuit fault status |

## Verification
The current-limit flag is applied in four patterns:
- A broken burst, whose two halves are each shorter than the trip window. It must never trip, which separates a consecutive count from an accumulating one.
- An unbroken burst of exactly the window length. It shows the exact trip cycle.
- A limit held high across a retry. It shows the open/retry cycle repeating with the fault held.
- A limit that is gone after a retry. It marks the exact cycle the fault clears.

Battery loss is applied twice. Once while the switch is on, to show the immediate cutoff and the rail drop. Once during the recovery period, held past its end, to show that the retry is suppressed and the fault is kept.

// File: rtl/hc_pkg.sv
// Shared types for the discharge hiccup controller.
package hc_pkg;
    // Switch control state: under-voltage off, switch on, recovery off.
    typedef enum logic [1:0] {
        S_UV    = 2'd0,
        S_ON    = 2'd1,
        S_RECOV = 2'd2
    } hc_state_t;
endpackage

// File: rtl/hc_tick_timer.sv
// Saturating tick counter.
// Counts advance pulses up to LIMIT and holds there; done is high at LIMIT.
// Assumes LIMIT >= 1. A clear wins over an advance.
module hc_tick_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // Count advances, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (adv && cnt != LIM_V) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == LIM_V);

    // A clear leaves the timer not done in the next cycle (count restart).
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !done);
endmodule

// File: rtl/hc_batt_qual.sv
// Battery presence qualifier.
// Raises rail_en once batt_ok has been high for QUAL_TICKS ticks in a row.
// Drops it as soon as batt_ok falls.
// Assumes batt_ok is already synchronous to clk.
module hc_batt_qual #(
    parameter int QUAL_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic batt_ok,
    output logic rail_en
);
    hc_tick_timer #(.LIMIT(QUAL_TICKS)) u_qual_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!batt_ok),
        .adv  (tick),
        .done (rail_en)
    );

    // Battery loss removes the rail start in the next cycle.
    assert_rail_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !batt_ok |=> !rail_en);
endmodule

// File: rtl/hc_hiccup_fsm.sv
// Discharge switch hiccup state machine.
// Qualifies the current limit over TRIP_TICKS consecutive ticks.
// On a trip it holds the switch off for OFF_TICKS ticks, then retries.
// It keeps the fault flag until a clean TRIP_TICKS window passes with the switch on.
// Battery undervoltage forces the switch off and blocks retries.
// Assumes all inputs are synchronous to clk and tick is one clock wide.
module hc_hiccup_fsm
    import hc_pkg::*;
#(
    parameter int TRIP_TICKS = 3,
    parameter int OFF_TICKS  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic batt_ok,
    input  logic ilim,
    output logic sw_en,
    output logic fault
);
    hc_state_t state, state_nx;
    logic      trip_done;
    logic      off_done;
    logic      clean_done;
    logic      in_on;

    assign in_on = (state == S_ON);

    // Consecutive current-limit ticks while on; any low clock restarts it.
    hc_tick_timer #(.LIMIT(TRIP_TICKS)) u_trip_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!in_on || !ilim),
        .adv  (tick && ilim),
        .done (trip_done)
    );

    // Recovery off period.
    hc_tick_timer #(.LIMIT(OFF_TICKS)) u_off_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state != S_RECOV),
        .adv  (tick),
        .done (off_done)
    );

    // Consecutive clean ticks while on, used to release the fault.
    hc_tick_timer #(.LIMIT(TRIP_TICKS)) u_clean_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!in_on || ilim),
        .adv  (tick && !ilim),
        .done (clean_done)
    );

    // Next-state selection; undervoltage takes priority over everything.
    always_comb begin
        state_nx = state;
        if (!batt_ok) begin
            state_nx = S_UV;
        end else begin
            case (state)
                S_UV:    state_nx = S_ON;
                S_ON:    if (trip_done) state_nx = S_RECOV;
                S_RECOV: if (off_done)  state_nx = S_ON;
                default: state_nx = S_UV;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_UV;
        end else begin
            state <= state_nx;
        end
    end

    // Fault flag: set on a trip, cleared by a clean on-window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault <= 1'b0;
        end else if (in_on && batt_ok && trip_done) begin
            fault <= 1'b1;
        end else if (in_on && batt_ok && clean_done) begin
            fault <= 1'b0;
        end
    end

    assign sw_en = in_on;

    // Undervoltage opens the switch one clock later.
    assert_uv_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !batt_ok |=> !sw_en);

    // A qualified trip opens the switch and flags the fault.
    assert_trip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_on && batt_ok && trip_done) |=> (fault && !sw_en));

    // The switch stays open until the recovery period has run out.
    assert_hold_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RECOV && !off_done) |=> !sw_en);

    // The fault is only released while the switch is on.
    assert_fault_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault) |-> sw_en);
endmodule

// File: rtl/dsg_hiccup_ctrl.sv
// Battery discharge short-circuit hiccup controller, top level.
// Combines the battery qualifier, which gates the rail start, with the hiccup
// state machine, which drives the switch and the fault flag.
// Periods are in timebase ticks: with a 10 us tick the defaults give a
// 100 us rail qualification, a 250 us trip window and a 2 s recovery.
module dsg_hiccup_ctrl #(
    parameter int QUAL_TICKS = 10,
    parameter int TRIP_TICKS = 25,
    parameter int OFF_TICKS  = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic batt_ok,
    input  logic ilim,
    output logic sw_en,
    output logic rail_en,
    output logic fault
);
    hc_batt_qual #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .batt_ok(batt_ok),
        .rail_en(rail_en)
    );

    hc_hiccup_fsm #(.TRIP_TICKS(TRIP_TICKS), .OFF_TICKS(OFF_TICKS)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .batt_ok(batt_ok),
        .ilim   (ilim),
        .sw_en  (sw_en),
        .fault  (fault)
    );

    // Outputs are all low right after reset.
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!sw_en && !rail_en && !fault));
endmodule

// File: tb/dsg_hiccup_ctrl_bench.sv
// Directed bench for the discharge hiccup controller.
module dsg_hiccup_ctrl_bench;
    localparam int QT = 4;
    localparam int TT = 3;
    localparam int OT = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic batt_ok = 1'b0;
    logic ilim = 1'b0;
    logic sw_en, rail_en, fault;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    dsg_hiccup_ctrl #(.QUAL_TICKS(QT), .TRIP_TICKS(TT), .OFF_TICKS(OT)) u_dsg_hiccup_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .batt_ok(batt_ok),
        .ilim(ilim), .sw_en(sw_en), .rail_en(rail_en), .fault(fault)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "sw_en", sw_en, 1'b0);
        check("R1", "rail_en", rail_en, 1'b0);
        check("R1", "fault", fault, 1'b0);
    endtask

    task automatic t_connect();
        @(negedge clk) batt_ok = 1'b1;
        @(negedge clk);
        check("R2", "sw_en on connect", sw_en, 1'b1);
        check("R3", "rail_en before qual", rail_en, 1'b0);
        ticks(QT - 1);
        check("R3", "rail_en one tick short", rail_en, 1'b0);
        ticks(1);
        check("R3", "rail_en qualified", rail_en, 1'b1);
    endtask

    task automatic t_glitch();
        @(negedge clk) ilim = 1'b1;
        ticks(TT - 1);
        @(negedge clk) ilim = 1'b0;
        @(negedge clk) ilim = 1'b1;
        ticks(TT - 1);
        @(negedge clk);
        check("R5", "sw_en after broken burst", sw_en, 1'b1);
        check("R5", "fault after broken burst", fault, 1'b0);
        ilim = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_trip();
        @(negedge clk) ilim = 1'b1;
        ticks(TT);
        check("R4", "sw_en at last trip tick", sw_en, 1'b1);
        @(negedge clk);
        check("R4", "sw_en after trip", sw_en, 1'b0);
        check("R4", "fault after trip", fault, 1'b1);
        check("R3", "rail_en held in hiccup", rail_en, 1'b1);
        ilim = 1'b0;
    endtask

    task automatic t_recover();
        ticks(OT - 1);
        check("R6", "sw_en one tick before end", sw_en, 1'b0);
        ticks(1);
        check("R6", "sw_en at last off tick", sw_en, 1'b0);
        @(negedge clk);
        check("R6", "sw_en retry", sw_en, 1'b1);
        check("R8", "fault kept at retry", fault, 1'b1);
    endtask

    task automatic t_persist();
        @(negedge clk) ilim = 1'b1;
        ticks(TT);
        @(negedge clk);
        check("R7", "sw_en off again", sw_en, 1'b0);
        ticks(OT);
        @(negedge clk);
        check("R7", "sw_en second retry", sw_en, 1'b1);
        check("R7", "fault held", fault, 1'b1);
        ticks(TT);
        @(negedge clk);
        check("R7", "sw_en third trip", sw_en, 1'b0);
        check("R7", "fault still held", fault, 1'b1);
    endtask

    task automatic t_clear();
        @(negedge clk) ilim = 1'b0;
        ticks(OT);
        @(negedge clk);
        check("R6", "sw_en retry clean", sw_en, 1'b1);
        ticks(TT - 1);
        check("R8", "fault before window", fault, 1'b1);
        ticks(1);
        check("R8", "fault at last clean tick", fault, 1'b1);
        @(negedge clk);
        check("R8", "fault cleared", fault, 1'b0);
    endtask

    task automatic t_uv();
        @(negedge clk) batt_ok = 1'b0;
        @(negedge clk);
        check("R9", "sw_en on undervoltage", sw_en, 1'b0);
        check("R3", "rail_en on undervoltage", rail_en, 1'b0);
        batt_ok = 1'b1;
        @(negedge clk);
        check("R2", "sw_en on reconnect", sw_en, 1'b1);
        ilim = 1'b1;
        ticks(TT);
        @(negedge clk);
        check("R4", "trip before uv", fault, 1'b1);
        batt_ok = 1'b0;
        ilim = 1'b0;
        ticks(OT + 2);
        @(negedge clk);
        check("R9", "no retry under uv", sw_en, 1'b0);
        batt_ok = 1'b1;
        @(negedge clk);
        check("R9", "sw_en after uv ends", sw_en, 1'b1);
        check("R9", "fault kept across uv", fault, 1'b1);
        check("R3", "rail_en requalifying", rail_en, 1'b0);
        ticks(TT);
        @(negedge clk);
        check("R8", "fault cleared after uv", fault, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_connect();
        t_glitch();
        t_trip();
        t_recover();
        t_persist();
        t_clear();
        t_uv();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule